// File: doc/BRIEF.md
# Dual Data Pointer with Auto-Toggle

This block keeps two 16-bit memory address pointers for a processor core. Each pointer is reached as two byte registers, one for the low byte and one for the high byte. A control byte chooses which pointer currently drives the memory address output. The same byte holds one step-direction bit per pointer and an auto-toggle enable. Pointer 0 sits at the lowest register indices, so code that only ever touches pointer 0 sees a single plain pointer.

The core decodes instructions elsewhere and signals them to this block on three strobes:

- a step strobe moves the active pointer up or down by one;
- an instruction strobe marks completion of any pointer-based instruction;
- a control-increment strobe flips the select bit.

With auto-toggle on, every pointer-based instruction hands over to the other pointer. A copy loop can then alternate between source and destination without extra instructions. The step of an instruction always lands on the pointer that was active before the hand-over.

Register indices (wr_addr and rd_addr):

| Index | Register |
|---|---|
| 0 | Pointer 0, low byte |
| 1 | Pointer 0, high byte |
| 2 | Pointer 1, low byte |
| 3 | Pointer 1, high byte |
| 4 | Control byte |
| 5 to 7 | Unused |

Top module: `dual_ptr_unit`

## Requirements
- R1: After a synchronous active-low reset, both pointers are 0x0000, the control byte reads 0x00 and act_ptr is 0x0000.
- R2: Register indices are as follows: 0 is the low byte of pointer 0, 1 is the high byte of pointer 0, 2 is the low byte of pointer 1, 3 is the high byte of pointer 1, and 4 is the control byte. A write lands on the next rising edge, and rd_data shows the addressed byte combinationally. Indices 5 to 7 read 0x00, and writes to them change nothing.
- R3: act_ptr equals pointer 1 when control bit 0 is 1, and pointer 0 when it is 0.
- R4: A step strobe changes only the active pointer; the inactive pointer keeps its value.
- R5: Control bit 6 sets the direction of pointer 0 and bit 7 sets the direction of pointer 1. A 0 means +1 and a 1 means -1, with wrap modulo 65536.
- R6: The control-increment strobe inverts bit 0 and leaves bits 7, 6 and 5 unchanged.
- R7: With control bit 5 set, the instruction strobe inverts bit 0 on the same edge. A step given in the same cycle applies to the pointer that was active before the inversion. With bit 5 clear, the instruction strobe has no effect.
- R8: Control bits 4 to 1 always read 0, whatever value is written to them.
- R9: A write to a pointer byte takes priority over a step of that pointer in the same cycle; the written byte takes the new value and the other byte is kept. A write to the control byte overrides both strobe-driven flips. The control-increment strobe and an enabled auto-toggle in the same cycle cancel each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Register index for writes |
| wr_data | input | 8 | Write data |
| inc_ptr | input | 1 | Step the active pointer |
| ptr_instr | input | 1 | A pointer-based instruction completes |
| sel_inc | input | 1 | Increment of the control byte (flips select) |
| rd_addr | input | 3 | Register index for readback |
| rd_data | output | 8 | Readback byte |
| act_ptr | output | 16 | Active pointer value for addressing |

## Verification
The hardest situations are the ones where several sources act on one register in the same cycle. These include a step that coincides with a byte write to the active pointer, and an auto-toggle that coincides with a control-increment strobe or a control write. Directed cases set each collision up on purpose. A long random run then drives all strobes and writes independently, so the collisions also occur in many mixes of direction and toggle settings. After every cycle, all readable indices and act_ptr are compared with a bench model.

// File: rtl/dual_ptr_pkg.sv
// Package: shared control-byte layout for the dual pointer unit.
// Assumes an 8-bit control byte; the bit positions are decoded by software.
package dual_ptr_pkg;
    localparam int CTL_SEL_BIT  = 0;
    localparam int CTL_TOG_BIT  = 5;
    localparam int CTL_DIR0_BIT = 6;
    localparam int CTL_DIR1_BIT = 7;

    typedef struct packed {
        logic dir1;
        logic dir0;
        logic tog;
        logic sel;
    } ctl_t;

    // Build the readback byte; unimplemented bits are zero.
    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        logic [7:0] b;
        b = 8'h00;
        b[CTL_SEL_BIT]  = c.sel;
        b[CTL_TOG_BIT]  = c.tog;
        b[CTL_DIR0_BIT] = c.dir0;
        b[CTL_DIR1_BIT] = c.dir1;
        return b;
    endfunction

    // Extract the implemented fields from a written byte.
    function automatic ctl_t byte_to_ctl(input logic [7:0] b);
        ctl_t c;
        c.sel  = b[CTL_SEL_BIT];
        c.tog  = b[CTL_TOG_BIT];
        c.dir0 = b[CTL_DIR0_BIT];
        c.dir1 = b[CTL_DIR1_BIT];
        return c;
    endfunction
endpackage

// File: rtl/dual_ptr_word.sv
// Module: one pointer register built from byte lanes.
// Byte writes take priority over a step in the same cycle; the step wraps.
// Assumes PTR_W is a multiple of 8.
module dual_ptr_word #(
    parameter int PTR_W = 16,
    localparam int LANES = PTR_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_we,
    input  logic [7:0]       lane_data,
    input  logic             step,
    input  logic             down,
    output logic [PTR_W-1:0] value
);
    logic [PTR_W-1:0] stepped;

    // Next value for a step, up or down with natural wrap.
    always_comb begin
        stepped = down ? value - PTR_W'(1) : value + PTR_W'(1);
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Update one byte lane: reset, write, step, or hold.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    value[8*g +: 8] <= 8'h00;
                else if (lane_we[g])
                    value[8*g +: 8] <= lane_data;
                else if (step && (lane_we == '0))
                    value[8*g +: 8] <= stepped[8*g +: 8];
            end
        end
    endgenerate
endmodule

// File: rtl/dual_ptr_ctl.sv
// Module: control register holding select, toggle enable and directions.
// A write overrides strobes; increment strobe and auto-toggle XOR together.
module dual_ptr_ctl
    import dual_ptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  ctl_t wr_val,
    input  logic sel_inc,
    input  logic instr,
    output ctl_t ctl
);
    logic flip;

    // Net select inversion from the two strobe sources.
    always_comb begin
        flip = sel_inc ^ (instr & ctl.tog);
    end

    // Register update: reset, software write, or select flip.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr)
            ctl <= wr_val;
        else if (flip)
            ctl.sel <= ~ctl.sel;
    end
endmodule

// File: rtl/dual_ptr_rdmux.sv
// Module: readback multiplexer over both pointers and the control byte.
// Unmapped indices return zero.
module dual_ptr_rdmux
    import dual_ptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 3,
    localparam int LANES = PTR_W / 8
) (
    input  logic [PTR_W-1:0]  ptr0,
    input  logic [PTR_W-1:0]  ptr1,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);
    // Select the addressed byte.
    always_comb begin
        data = 8'h00;
        for (int b = 0; b < LANES; b++) begin
            if (int'(addr) == b)          data = ptr0[8*b +: 8];
            if (int'(addr) == LANES + b)  data = ptr1[8*b +: 8];
        end
        if (int'(addr) == 2*LANES) data = ctl_to_byte(ctl);
    end
endmodule

// File: rtl/dual_ptr_unit.sv
// Module: top of the dual data pointer unit.
// Decodes byte writes, routes the step to the active pointer, and drives
// the active address. Assumes 2*PTR_W/8+1 indices fit in ADDR_W bits.
module dual_ptr_unit
    import dual_ptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              inc_ptr,
    input  logic              ptr_instr,
    input  logic              sel_inc,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [PTR_W-1:0]  act_ptr
);
    localparam int LANES    = PTR_W / 8;
    localparam int CTL_ADDR = 2 * LANES;

    logic [PTR_W-1:0] ptr_val [2];
    logic [LANES-1:0] lane_we [2];
    ctl_t             ctl_q;
    logic             ctl_we;
    logic [1:0]       dir_vec;

    // Control write decode.
    always_comb begin
        ctl_we  = wr_en && (int'(wr_addr) == CTL_ADDR);
        dir_vec = {ctl_q.dir1, ctl_q.dir0};
    end

    genvar k, b;
    generate
        for (k = 0; k < 2; k++) begin : g_ptr
            for (b = 0; b < LANES; b++) begin : g_we
                // Lane write decode for pointer k, byte b.
                always_comb begin
                    lane_we[k][b] = wr_en && (int'(wr_addr) == k*LANES + b);
                end
            end

            dual_ptr_word #(.PTR_W(PTR_W)) u_word (
                .clk       (clk),
                .rst_n     (rst_n),
                .lane_we   (lane_we[k]),
                .lane_data (wr_data),
                .step      (inc_ptr && (ctl_q.sel == 1'(k))),
                .down      (dir_vec[k]),
                .value     (ptr_val[k])
            );
        end
    endgenerate

    dual_ptr_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctl_we),
        .wr_val  (byte_to_ctl(wr_data)),
        .sel_inc (sel_inc),
        .instr   (ptr_instr),
        .ctl     (ctl_q)
    );

    dual_ptr_rdmux #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_rd (
        .ptr0 (ptr_val[0]),
        .ptr1 (ptr_val[1]),
        .ctl  (ctl_q),
        .addr (rd_addr),
        .data (rd_data)
    );

    // Active address output.
    always_comb begin
        act_ptr = ctl_q.sel ? ptr_val[1] : ptr_val[0];
    end
endmodule

// File: rtl/dual_ptr_chk.sv
// Module: property checker bound to dual_ptr_unit.
module dual_ptr_chk #(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              inc_ptr,
    input logic              ptr_instr,
    input logic              sel_inc,
    input logic [PTR_W-1:0]  p0,
    input logic [PTR_W-1:0]  p1,
    input logic              sel,
    input logic              tog,
    input logic              dir0,
    input logic [PTR_W-1:0]  act_ptr
);
    localparam int LANES = PTR_W / 8;
    logic p0_hit, p1_hit, c_hit;

    // Which register a write touches.
    always_comb begin
        p0_hit = wr_en && (int'(wr_addr) < LANES);
        p1_hit = wr_en && (int'(wr_addr) >= LANES) && (int'(wr_addr) < 2*LANES);
        c_hit  = wr_en && (int'(wr_addr) == 2*LANES);
    end

    // R1: reset clears the address output and the select bit.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (act_ptr == '0) && !sel);

    // R4: stepping pointer 0 leaves pointer 1 alone.
    a_r4_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ptr && !sel && !p1_hit) |=> $stable(p1));

    // R5: pointer 0 in the down direction decrements by one.
    a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ptr && !sel && dir0 && !p0_hit) |=> (p0 == PTR_W'($past(p0) - 1'b1)));

    // R6: the increment strobe alone inverts the select bit.
    a_r6_sel_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_inc && !(ptr_instr && tog) && !c_hit) |=> (sel != $past(sel)));

    // R7: an enabled auto-toggle alone inverts the select bit.
    a_r7_auto_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_instr && tog && !sel_inc && !c_hit) |=> (sel != $past(sel)));

    // R9: both flip sources at once leave the select bit unchanged.
    a_r9_flip_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_instr && tog && sel_inc && !c_hit) |=> (sel == $past(sel)));
endmodule

bind dual_ptr_unit dual_ptr_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .inc_ptr   (inc_ptr),
    .ptr_instr (ptr_instr),
    .sel_inc   (sel_inc),
    .p0        (ptr_val[0]),
    .p1        (ptr_val[1]),
    .sel       (ctl_q.sel),
    .tog       (ctl_q.tog),
    .dir0      (ctl_q.dir0),
    .act_ptr   (act_ptr)
);

// File: tb/dual_ptr_unit_test.sv
module dual_ptr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        inc_ptr = 1'b0;
    logic        ptr_instr = 1'b0;
    logic        sel_inc = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] act_ptr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model of the requirements.
    logic [15:0] m_p [2];
    logic        m_sel, m_tog, m_dir0, m_dir1;

    dual_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .inc_ptr(inc_ptr), .ptr_instr(ptr_instr),
        .sel_inc(sel_inc), .rd_addr(rd_addr), .rd_data(rd_data),
        .act_ptr(act_ptr)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_byte(input int a);
        case (a)
            0: return m_p[0][7:0];
            1: return m_p[0][15:8];
            2: return m_p[1][7:0];
            3: return m_p[1][15:8];
            4: return {m_dir1, m_dir0, m_tog, 4'b0000, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Compare every readable index and the address output with the model.
    task automatic verify(input string req);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            chk(req, {8'h00, rd_data}, {8'h00, exp_byte(a)});
        end
        chk(req, act_ptr, m_sel ? m_p[1] : m_p[0]);
    endtask

    // Drive one cycle of stimulus and advance the model.
    task automatic op(input bit we, input int wa, input logic [7:0] wd,
                      input bit inc, input bit ins, input bit si);
        logic [15:0] np [2];
        @(negedge clk);
        wr_en = we; wr_addr = 3'(wa); wr_data = wd;
        inc_ptr = inc; ptr_instr = ins; sel_inc = si;
        for (int k = 0; k < 2; k++) begin
            np[k] = m_p[k];
            if (we && (wa == 2*k))
                np[k][7:0] = wd;
            else if (we && (wa == 2*k + 1))
                np[k][15:8] = wd;
            else if (inc && (int'(m_sel) == k))
                np[k] = ((k == 0) ? m_dir0 : m_dir1) ? m_p[k] - 16'd1 : m_p[k] + 16'd1;
        end
        @(posedge clk);
        m_p[0] = np[0]; m_p[1] = np[1];
        if (we && wa == 4) begin
            m_sel = wd[0]; m_tog = wd[5]; m_dir0 = wd[6]; m_dir1 = wd[7];
        end else begin
            m_sel = m_sel ^ si ^ (ins & m_tog);
        end
        #1;
        wr_en = 1'b0; inc_ptr = 1'b0; ptr_instr = 1'b0; sel_inc = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_p[0] = '0; m_p[1] = '0;
        m_sel = 0; m_tog = 0; m_dir0 = 0; m_dir1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        verify("R1");
        chk("R1", act_ptr, 16'h0000);
        rst_n = 1'b1;

        // R2: byte map and readback.
        op(1, 0, 8'h34, 0, 0, 0); op(1, 1, 8'h12, 0, 0, 0);
        op(1, 2, 8'hCD, 0, 0, 0); op(1, 3, 8'hAB, 0, 0, 0);
        verify("R2");
        op(1, 5, 8'h77, 0, 0, 0); op(1, 7, 8'hFF, 0, 0, 0);
        verify("R2");

        // R3: address output follows the select bit.
        chk("R3", act_ptr, 16'h1234);
        op(1, 4, 8'h01, 0, 0, 0);
        chk("R3", act_ptr, 16'hABCD);

        // R4: step pointer 1, pointer 0 unchanged.
        op(0, 0, 8'h00, 1, 0, 0);
        rd_addr = 3'd0; #1;
        chk("R4", {8'h00, rd_data}, 16'h0034);
        chk("R4", act_ptr, 16'hABCE);

        // R5: wrap upward on pointer 1, downward on pointer 0.
        op(1, 2, 8'hFF, 0, 0, 0); op(1, 3, 8'hFF, 0, 0, 0);
        op(0, 0, 8'h00, 1, 0, 0);
        chk("R5", act_ptr, 16'h0000);
        op(1, 0, 8'h00, 0, 0, 0); op(1, 1, 8'h00, 0, 0, 0);
        op(1, 4, 8'h40, 0, 0, 0);
        op(0, 0, 8'h00, 1, 0, 0);
        chk("R5", act_ptr, 16'hFFFF);
        op(1, 4, 8'h81, 0, 0, 0);
        op(0, 0, 8'h00, 1, 0, 0);
        chk("R5", act_ptr, 16'hFFFF);
        verify("R5");

        // R6: increment strobe flips only bit 0.
        op(1, 4, 8'hE1, 0, 0, 0);
        op(0, 0, 8'h00, 0, 0, 1);
        rd_addr = 3'd4; #1;
        chk("R6", {8'h00, rd_data}, 16'h00E0);

        // R8: unimplemented bits read zero.
        op(1, 4, 8'h1E, 0, 0, 0);
        rd_addr = 3'd4; #1;
        chk("R8", {8'h00, rd_data}, 16'h0000);

        // R7: toggle with a same-cycle step on the old pointer.
        op(1, 0, 8'h10, 0, 0, 0); op(1, 1, 8'h00, 0, 0, 0);
        op(1, 4, 8'h20, 0, 0, 0);
        op(0, 0, 8'h00, 1, 1, 0);
        rd_addr = 3'd0; #1;
        chk("R7", {8'h00, rd_data}, 16'h0011);
        chk("R7", act_ptr, m_p[1]);
        op(1, 4, 8'h00, 0, 0, 0);
        op(0, 0, 8'h00, 0, 1, 0);
        chk("R7", act_ptr, 16'h0011);

        // R9: write beats step; control write beats strobes; flips cancel.
        op(1, 0, 8'h80, 1, 0, 0);
        chk("R9", act_ptr, 16'h0080);
        op(1, 4, 8'h20, 0, 1, 1);
        rd_addr = 3'd4; #1;
        chk("R9", {8'h00, rd_data}, 16'h0020);
        op(0, 0, 8'h00, 0, 1, 1);
        chk("R9", act_ptr, 16'h0080);
        verify("R9");

        // Random mix with a fixed seed.
        void'($urandom(32'd1234));
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            op(r[3:0] < 4'd5, int'(r[6:4]) % 5, r[15:8],
               r[16], r[17], r[18] & r[19]);
            verify("R4");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule